// File: doc/BRIEF.md
# UART Interrupt Status and Mask

This block turns a UART's live status flags into an interrupt status register and drives one interrupt request line. On each clock it rebuilds the transmit and receive status bits from the current flags. The receive bit follows either "at least one byte waiting" or "receive FIFO full", chosen by a select bit taken from the first mode register. A break detected on the line sets a sticky break-change bit. Software clears that bit only through a miscellaneous command with code 5.

A bus write loads the interrupt mask. The request line is high while any status bit that is also enabled in the mask is set. The status bits, the mask and the request line all come from registers. They change on the clock edge that follows the stimulus, so the request line never glitches.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, `status` and `mask` are all zeros and `irq` is low, whatever the inputs are doing.
- R2: Status bit 0 (transmit) equals `tx_ready` as it stood before the most recent rising clock edge.
- R3: Status bit 1 (receive) follows `fifo_full` when `rx_sel_full` is 1, and follows `rx_ready` when `rx_sel_full` is 0. It takes both inputs as they stood before the most recent edge.
- R4: A cycle with `brk_pulse` high sets status bit 2 (break change) at the next edge. The bit then stays set through any number of cycles until a clear command arrives.
- R5: A cycle with `cmd_we` high and `cmd_misc` equal to 5 clears status bit 2 at the next edge. Any other `cmd_misc` value leaves the bit unchanged. When a break pulse and the clear command fall in the same cycle, the bit ends up set.
- R6: A cycle with `mask_we` high loads `mask_wdata` into `mask` at the next edge. Without `mask_we`, `mask` holds its value.
- R7: `irq` is high exactly when the bitwise AND of `status` and `mask` is nonzero. It updates on the same edge as `status` and `mask`.
- R8: Status bits 3 to 6 and bit 7 (change of state) always read 0. Setting the mask bits at those positions never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_ready | input | 1 | Transmitter can accept a byte |
| rx_ready | input | 1 | At least one received byte is waiting |
| fifo_full | input | 1 | Receive FIFO is full |
| rx_sel_full | input | 1 | Mode register 1 bit 6: 1 selects FIFO-full as the receive source |
| brk_pulse | input | 1 | One-cycle pulse when a break is detected |
| cmd_we | input | 1 | Command register write strobe |
| cmd_misc | input | 3 | Miscellaneous-command field of the command write |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value |
| status | output | 8 | Interrupt status register |
| mask | output | 8 | Interrupt mask register |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block is due one rising edge after the stimulus that causes it. This applies to the status bits, the mask and the request line alike, because all three are registers loaded from the same next-state values. The driver applies each stimulus on a falling edge and enqueues the expected status, mask and request. The monitor compares those values two time units after the following rising edge, so each comparison lands in the first cycle where the new value is valid. The sticky break bit and the clear command are checked over several consecutive cycles to cover holding, clearing and the same-cycle case.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   // Status bit positions: software decodes these, so they are fixed.
   localparam int unsigned TX_BIT  = 0;
   localparam int unsigned RX_BIT  = 1;
   localparam int unsigned BRK_BIT = 2;
   localparam int unsigned COS_BIT = 7;

   // Default layout of the miscellaneous-command field.
   localparam int unsigned MISC_W_DEF   = 3;
   localparam int unsigned CLR_BRK_CODE = 5;

   // Selection of the receive interrupt source.
   typedef enum logic {
      RX_SRC_ANY  = 1'b0,
      RX_SRC_FULL = 1'b1
   } rx_src_e;

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
   import uart_irq_pkg::*;
#(
   parameter int ST_W         = 8,
   parameter int MISC_W       = MISC_W_DEF,
   parameter int CLR_CODE     = CLR_BRK_CODE,
   parameter bit BRK_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_ready,
   input  logic              rx_ready,
   input  logic              fifo_full,
   input  logic              rx_sel_full,
   input  logic              brk_pulse,
   input  logic              cmd_we,
   input  logic [MISC_W-1:0] cmd_misc,
   output logic [ST_W-1:0]   st_next,
   output logic [ST_W-1:0]   st_q
);

   localparam logic [MISC_W-1:0] CLR_VAL = MISC_W'(CLR_CODE);

   logic    brk_clr;
   logic    brk_next;
   logic    rx_src;
   rx_src_e rx_mode;

   assign brk_clr = cmd_we && (cmd_misc == CLR_VAL);
   assign rx_mode = rx_src_e'(rx_sel_full);

   always_comb begin
      unique case (rx_mode)
         RX_SRC_FULL: rx_src = fifo_full;
         default:     rx_src = rx_ready;
      endcase
   end

   // Priority between a new break and a clear in the same cycle.
   generate
      if (BRK_SET_WINS) begin : g_set_wins
         assign brk_next = brk_pulse | (st_q[BRK_BIT] & ~brk_clr);
      end else begin : g_clr_wins
         assign brk_next = (brk_pulse | st_q[BRK_BIT]) & ~brk_clr;
      end
   endgenerate

   always_comb begin
      st_next          = '0;
      st_next[TX_BIT]  = tx_ready;
      st_next[RX_BIT]  = rx_src;
      st_next[BRK_BIT] = brk_next;
      st_next[COS_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_next;
   end

endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
   parameter int ST_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mask_we,
   input  logic [ST_W-1:0] mask_wdata,
   output logic [ST_W-1:0] mask_next,
   output logic [ST_W-1:0] mask_q
);

   assign mask_next = mask_we ? mask_wdata : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_next;
   end

endmodule

// File: rtl/uart_irq_out.sv
module uart_irq_out #(
   parameter int ST_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] st_next,
   input  logic [ST_W-1:0] mask_next,
   output logic            irq
);

   logic [ST_W-1:0] hit;
   assign hit = st_next & mask_next;

   // Registered from next-state values so the line moves with the registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |hit;
   end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int ST_W         = 8,
   parameter int MISC_W       = MISC_W_DEF,
   parameter int CLR_CODE     = CLR_BRK_CODE,
   parameter bit BRK_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_ready,
   input  logic              rx_ready,
   input  logic              fifo_full,
   input  logic              rx_sel_full,
   input  logic              brk_pulse,
   input  logic              cmd_we,
   input  logic [MISC_W-1:0] cmd_misc,
   input  logic              mask_we,
   input  logic [ST_W-1:0]   mask_wdata,
   output logic [ST_W-1:0]   status,
   output logic [ST_W-1:0]   mask,
   output logic              irq
);

   generate
      if (ST_W <= COS_BIT) begin : g_bad_width
         $error("uart_irq_ctrl: ST_W must exceed the highest status bit index");
      end
      if (CLR_CODE >= (1 << MISC_W)) begin : g_bad_code
         $error("uart_irq_ctrl: CLR_CODE does not fit in MISC_W bits");
      end
   endgenerate

   logic [ST_W-1:0] st_next;
   logic [ST_W-1:0] mask_next;

   uart_irq_src #(
      .ST_W(ST_W), .MISC_W(MISC_W), .CLR_CODE(CLR_CODE), .BRK_SET_WINS(BRK_SET_WINS)
   ) u_src (
      .clk(clk), .rst_n(rst_n),
      .tx_ready(tx_ready), .rx_ready(rx_ready), .fifo_full(fifo_full),
      .rx_sel_full(rx_sel_full), .brk_pulse(brk_pulse),
      .cmd_we(cmd_we), .cmd_misc(cmd_misc),
      .st_next(st_next), .st_q(status)
   );

   uart_irq_mask #(.ST_W(ST_W)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .mask_next(mask_next), .mask_q(mask)
   );

   uart_irq_out #(.ST_W(ST_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .st_next(st_next), .mask_next(mask_next),
      .irq(irq)
   );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
   import uart_irq_pkg::*;
#(
   parameter int ST_W     = 8,
   parameter int MISC_W   = MISC_W_DEF,
   parameter int CLR_CODE = CLR_BRK_CODE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_ready,
   input logic              rx_ready,
   input logic              fifo_full,
   input logic              rx_sel_full,
   input logic              brk_pulse,
   input logic              cmd_we,
   input logic [MISC_W-1:0] cmd_misc,
   input logic              mask_we,
   input logic [ST_W-1:0]   mask_wdata,
   input logic [ST_W-1:0]   status,
   input logic [ST_W-1:0]   mask,
   input logic              irq
);

   logic past_ok;
   logic clr_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign clr_cmd = cmd_we && (cmd_misc == MISC_W'(CLR_CODE));

   p_tx_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> status[TX_BIT] == $past(tx_ready));

   p_rx_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> status[RX_BIT] == ($past(rx_sel_full) ? $past(fifo_full) : $past(rx_ready)));

   p_brk_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |=> status[BRK_BIT]);

   p_brk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status[BRK_BIT] && !clr_cmd) |=> status[BRK_BIT]);

   p_brk_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && !brk_pulse) |=> !status[BRK_BIT]);

   p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> mask == $past(mask_wdata));

   p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(mask));

   p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(status & mask));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
   .ST_W(ST_W), .MISC_W(MISC_W), .CLR_CODE(CLR_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .tx_ready(tx_ready), .rx_ready(rx_ready), .fifo_full(fifo_full),
   .rx_sel_full(rx_sel_full), .brk_pulse(brk_pulse),
   .cmd_we(cmd_we), .cmd_misc(cmd_misc),
   .mask_we(mask_we), .mask_wdata(mask_wdata),
   .status(status), .mask(mask), .irq(irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;

   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_ready = 1'b0, rx_ready = 1'b0, fifo_full = 1'b0;
   logic       rx_sel_full = 1'b0, brk_pulse = 1'b0, cmd_we = 1'b0, mask_we = 1'b0;
   logic [2:0] cmd_misc = 3'd0;
   logic [7:0] mask_wdata = 8'h00;
   logic [7:0] status, mask;
   logic       irq;

   always #(PERIOD/2) clk = ~clk;

   uart_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_ready(tx_ready), .rx_ready(rx_ready), .fifo_full(fifo_full),
      .rx_sel_full(rx_sel_full), .brk_pulse(brk_pulse),
      .cmd_we(cmd_we), .cmd_misc(cmd_misc),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .status(status), .mask(mask), .irq(irq)
   );

   typedef struct {
      logic [7:0] st;
      logic [7:0] mk;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 0;

   // Bench model of the register state.
   logic [7:0] m_st = 8'h00;
   logic [7:0] m_mk = 8'h00;

   task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and enqueue the expected result.
   task automatic drive(input logic tx, input logic rx, input logic ff, input logic sel,
                        input logic brk, input logic cwe, input logic [2:0] code,
                        input logic mwe, input logic [7:0] mdat, input string tag);
      exp_t e;
      logic brk_n;
      @(negedge clk);
      tx_ready = tx; rx_ready = rx; fifo_full = ff; rx_sel_full = sel;
      brk_pulse = brk; cmd_we = cwe; cmd_misc = code;
      mask_we = mwe; mask_wdata = mdat;
      if (brk)                         brk_n = 1'b1;
      else if (cwe && code == 3'd5)    brk_n = 1'b0;
      else                             brk_n = m_st[2];
      m_st = {5'b00000, brk_n, (sel ? ff : rx), tx};
      if (mwe) m_mk = mdat;
      e.st = m_st; e.mk = m_mk; e.irq = |(m_st & m_mk); e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, tag);
   endtask

   // Monitor: compare just after the edge on which the result is due.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, "status", status, e.st);
            check(e.tag, "mask",   mask,   e.mk);
            check(e.tag, "irq",    {7'd0, irq}, {7'd0, e.irq});
         end
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired got running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: inputs active during reset must not reach the registers.
      tx_ready = 1'b1; rx_ready = 1'b1; brk_pulse = 1'b1;
      mask_we = 1'b1; mask_wdata = 8'hFF;
      repeat (3) @(posedge clk);
      #2;
      check("R1", "status", status, 8'h00);
      check("R1", "mask",   mask,   8'h00);
      check("R1", "irq",    {7'd0, irq}, 8'h00);
      @(negedge clk);
      tx_ready = 1'b0; rx_ready = 1'b0; brk_pulse = 1'b0; mask_we = 1'b0;
      rst_n = 1'b1;
      idle("R1");

      // R2: transmit bit tracks tx_ready, masked off.
      drive(1, 0, 0, 0, 0, 0, 3'd0, 0, 8'h00, "R2");
      drive(0, 0, 0, 0, 0, 0, 3'd0, 0, 8'h00, "R2");
      drive(1, 0, 0, 0, 0, 0, 3'd0, 0, 8'h00, "R2");

      // R6/R7: unmask transmit, irq follows.
      drive(1, 0, 0, 0, 0, 0, 3'd0, 1, 8'h01, "R6");
      drive(0, 0, 0, 0, 0, 0, 3'd0, 0, 8'hFF, "R7");
      drive(1, 0, 0, 0, 0, 0, 3'd0, 0, 8'h00, "R7");

      // R3: receive source selection.
      drive(0, 1, 0, 0, 0, 0, 3'd0, 1, 8'h02, "R3");
      drive(0, 1, 0, 1, 0, 0, 3'd0, 0, 8'h00, "R3");
      drive(0, 1, 1, 1, 0, 0, 3'd0, 0, 8'h00, "R3");
      drive(0, 0, 1, 0, 0, 0, 3'd0, 0, 8'h00, "R3");

      // R4: sticky break.
      drive(0, 0, 0, 0, 1, 0, 3'd0, 1, 8'h04, "R4");
      idle("R4");
      idle("R4");
      idle("R4");

      // R5: other codes leave it, code 5 clears, same-cycle break wins.
      drive(0, 0, 0, 0, 0, 1, 3'd4, 0, 8'h00, "R5");
      drive(0, 0, 0, 0, 0, 1, 3'd7, 0, 8'h00, "R5");
      drive(0, 0, 0, 0, 0, 0, 3'd5, 0, 8'h00, "R5");
      drive(0, 0, 0, 0, 0, 1, 3'd5, 0, 8'h00, "R5");
      idle("R5");
      drive(0, 0, 0, 0, 1, 1, 3'd5, 0, 8'h00, "R5");
      idle("R5");

      // R8: unused positions stay zero and cannot raise irq.
      drive(1, 1, 1, 0, 0, 1, 3'd5, 1, 8'hF8, "R8");
      drive(1, 1, 1, 1, 1, 0, 3'd0, 0, 8'h00, "R8");
      drive(1, 1, 1, 1, 0, 0, 3'd0, 1, 8'hFF, "R8");

      // R1: asynchronous reset mid-run clears everything.
      idle("R1");
      repeat (2) @(posedge clk);
      #2;
      exp_q.delete();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", "status", status, 8'h00);
      check("R1", "mask",   mask,   8'h00);
      check("R1", "irq",    {7'd0, irq}, 8'h00);

      repeat (2) @(posedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule